// File: doc/BRIEF.md
# Ten-Bit Character Serializer with Comma Test Pattern

This block turns a stream of 10-bit line characters into a serial bit stream. It runs entirely on the serial bit clock. An internal counter divides that clock by ten and defines the character boundaries. On each boundary one character is captured, either the user's parallel word or a generated K28.5 comma, and its bits go out least significant bit first, one per bit clock.

A built-in test source replaces the user data with K28.5 when its active-low enable is asserted. It sends only the positive-disparity form, unless a second active-low control selects alternating disparity.

The output side is a small routing matrix driven by two controls, serial-select and loopback. It decides which of three stream outputs carry the serialized data, an external serial input or a static low. A receive-side output either passes the line receive input or, during loopback, carries the wrapped transmit stream.

Top module: `kchar_serializer`

## Requirements
- R1: A capture happens on the first clock edge after reset is released and then on every tenth bit-clock edge. `cap_tick` is high for exactly the one clock period after each capture edge and low in the nine periods in between.
- R2: For a character captured at edge E, bit i (bit 0 first) is on the selected serial output during the period after edge E+1+i. Consecutive characters follow with no gap.
- R3: With `pat_n` low and `alt_n` high, every captured character is +K28.5. Listed as bits 0 to 9 it is 0011111010, which is 10'h17C as a [9:0] vector.
- R4: With `pat_n` and `alt_n` both low, the first character after a capture with the pattern off is +K28.5. Later characters alternate with -K28.5, which is 1100000101 in bit order 0 to 9, or 10'h283.
- R5: `pat_n` and `alt_n` are sampled only at capture edges. A change in the middle of a character leaves that character's remaining bits unchanged.
- R6: With `ser_sel` low and `loop_en` low, `main_out` carries the serialized data and `aux_out` stays low.
- R7: With `ser_sel` high, `aux_out` carries the serialized data. With `loop_en` also low, `main_out` repeats `ext_in` one clock later.
- R8: With `loop_en` high, `main_out` stays low. `rx_out` carries, one clock late, the stream `main_out` would otherwise have sent: the serialized data when `ser_sel` is low, `ext_in` when it is high. `rx_line` is ignored.
- R9: With `loop_en` low, `rx_out` repeats `rx_line` one clock later.
- R10: While `rst` is high, `main_out`, `aux_out`, `rx_out` and `cap_tick` are low after the next clock edge. After release, the bit count restarts so that the capture of R1 happens on the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | 10 | Parallel character, bit 0 sent first |
| pat_n | input | 1 | Active-low K28.5 pattern enable |
| alt_n | input | 1 | Active-low alternating-disparity enable |
| loop_en | input | 1 | Wrap the line stream to the receive side |
| ser_sel | input | 1 | Move data to `aux_out`, pass `ext_in` on `main_out` |
| ext_in | input | 1 | External serial stream for pass-through |
| rx_line | input | 1 | Serial receive input from the line |
| cap_tick | output | 1 | High for the period after each capture edge |
| main_out | output | 1 | Main serial line output |
| aux_out | output | 1 | Auxiliary serial output |
| rx_out | output | 1 | Serial stream delivered to the receive side |

## Verification
A pattern-enable change can arrive in the same cycle that the bit counter sits in the middle of a character. The pattern logic decides only at the next capture edge. The bench provokes this by flipping `pat_n` partway through a character in both directions. It then judges that the character in flight arrives unchanged and that the following one is the correct code.

Loopback and split routing also act in the same cycle: `aux_out` carries the data while `rx_out` carries the toggling external stream and `main_out` stays low. Each output is compared bit by bit against what its own mode requires.

// File: rtl/kchar_ser_pkg.sv
package kchar_ser_pkg;
  localparam int CHAR_W = 10;

  // K28.5 as [9:0] vectors, bit 0 is transmitted first
  localparam logic [CHAR_W-1:0] K_POS = 10'h17C;
  localparam logic [CHAR_W-1:0] K_NEG = 10'h283;

  // routing modes, encoded as {loop_en, ser_sel}
  typedef enum logic [1:0] {
    RT_DIRECT     = 2'b00,
    RT_SPLIT      = 2'b01,
    RT_WRAP       = 2'b10,
    RT_WRAP_SPLIT = 2'b11
  } route_e;
endpackage

// File: rtl/kchar_bit_timer.sv
module kchar_bit_timer #(
  parameter int N = 10
) (
  input  logic clk,
  input  logic rst,
  output logic load,
  output logic cap_tick
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  assign load = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      cap_tick <= 1'b0;
    end else begin
      cnt_q    <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      cap_tick <= load;
    end
  end

  // R1: counter never leaves its range
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < N);

  // R1: the capture marker never lasts two periods
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    cap_tick |=> !cap_tick);
endmodule

// File: rtl/kchar_char_src.sv
module kchar_char_src
  import kchar_ser_pkg::*;
#(
  parameter int N = CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] par_data,
  input  logic         pat_n,
  input  logic         alt_n,
  output logic [N-1:0] char_out
);
  logic neg_q;  // next pattern character is the negative form

  always_comb begin
    if (!pat_n) char_out = (!alt_n && neg_q) ? N'(K_NEG) : N'(K_POS);
    else        char_out = par_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       neg_q <= 1'b0;
    else if (load) neg_q <= (!pat_n && !alt_n) ? ~neg_q : 1'b0;
  end

  // R4: alternating mode flips disparity at each capture
  p_alt_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !pat_n && !alt_n) |=> (neg_q != $past(neg_q)));

  // R4: a capture without alternation restarts on the positive form
  p_plus_first_r4: assert property (@(posedge clk) disable iff (rst)
    (load && (pat_n || alt_n)) |=> !neg_q);

  // R5: disparity state moves only at capture edges
  p_hold_mid_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(neg_q));
endmodule

// File: rtl/kchar_shifter.sv
module kchar_shifter #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] char_in,
  output logic         tx_bit
);
  logic [N-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)       sreg_q <= '0;
    else if (load) sreg_q <= char_in;
    else           sreg_q <= {1'b0, sreg_q[N-1:1]};
  end

  assign tx_bit = sreg_q[0];

  // R2: bit 0 of a captured character leads the stream
  p_bit0_first_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (tx_bit == $past(char_in[0])));
endmodule

// File: rtl/kchar_router.sv
module kchar_router
  import kchar_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_bit,
  input  logic loop_en,
  input  logic ser_sel,
  input  logic ext_in,
  input  logic rx_line,
  output logic main_out,
  output logic aux_out,
  output logic rx_out
);
  route_e mode;
  logic   main_d, aux_d, rx_d;

  always_comb begin
    mode   = route_e'({loop_en, ser_sel});
    main_d = 1'b0;
    aux_d  = 1'b0;
    rx_d   = rx_line;
    unique case (mode)
      RT_DIRECT:     main_d = tx_bit;
      RT_SPLIT: begin
        main_d = ext_in;
        aux_d  = tx_bit;
      end
      RT_WRAP:       rx_d = tx_bit;
      RT_WRAP_SPLIT: begin
        aux_d = tx_bit;
        rx_d  = ext_in;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_out <= 1'b0;
      aux_out  <= 1'b0;
      rx_out   <= 1'b0;
    end else begin
      main_out <= main_d;
      aux_out  <= aux_d;
      rx_out   <= rx_d;
    end
  end

  // R8: wrapped line keeps the main output quiet
  p_main_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> !main_out);

  // R6: auxiliary output idle unless serial-select is high
  p_aux_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !ser_sel |=> !aux_out);

  // R9: receive side follows the line when not wrapped
  p_rx_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> (rx_out == $past(rx_line)));

  // R7: pass-through repeats the external stream
  p_pass_main_r7: assert property (@(posedge clk) disable iff (rst)
    (ser_sel && !loop_en) |=> (main_out == $past(ext_in)));
endmodule

// File: rtl/kchar_serializer.sv
module kchar_serializer
  import kchar_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] par_data,
  input  logic              pat_n,
  input  logic              alt_n,
  input  logic              loop_en,
  input  logic              ser_sel,
  input  logic              ext_in,
  input  logic              rx_line,
  output logic              cap_tick,
  output logic              main_out,
  output logic              aux_out,
  output logic              rx_out
);
  logic              load;
  logic [CHAR_W-1:0] next_char;
  logic              tx_bit;

  kchar_bit_timer #(.N(CHAR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .cap_tick (cap_tick)
  );

  kchar_char_src #(.N(CHAR_W)) u_src (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .par_data (par_data),
    .pat_n    (pat_n),
    .alt_n    (alt_n),
    .char_out (next_char)
  );

  kchar_shifter #(.N(CHAR_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .char_in (next_char),
    .tx_bit  (tx_bit)
  );

  kchar_router u_route (
    .clk      (clk),
    .rst      (rst),
    .tx_bit   (tx_bit),
    .loop_en  (loop_en),
    .ser_sel  (ser_sel),
    .ext_in   (ext_in),
    .rx_line  (rx_line),
    .main_out (main_out),
    .aux_out  (aux_out),
    .rx_out   (rx_out)
  );
endmodule

// File: tb/kchar_serializer_bench.sv
`timescale 1ns/1ps
module kchar_serializer_bench;
  localparam logic [9:0] KP = 10'h17C;
  localparam logic [9:0] KN = 10'h283;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] par_data = '0;
  logic       pat_n = 1'b1, alt_n = 1'b1, loop_en = 1'b0, ser_sel = 1'b0;
  logic       ext_in = 1'b0, rx_line = 1'b0;
  logic       cap_tick, main_out, aux_out, rx_out;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  kchar_serializer u_kchar_serializer (
    .clk(clk), .rst(rst), .par_data(par_data), .pat_n(pat_n), .alt_n(alt_n),
    .loop_en(loop_en), .ser_sel(ser_sel), .ext_in(ext_in), .rx_line(rx_line),
    .cap_tick(cap_tick), .main_out(main_out), .aux_out(aux_out), .rx_out(rx_out)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // at a negedge just after a capture: drive inputs, wait until they are captured
  task automatic launch(input logic [9:0] d, input logic pn, input logic an,
                        input logic sel, input logic lb);
    par_data = d; pat_n = pn; alt_n = an; ser_sel = sel; loop_en = lb;
    repeat (10) @(negedge clk);
  endtask

  // gather one character on all outputs; optionally flip pat_n partway
  task automatic collect(output logic [9:0] m, output logic [9:0] a, output logic [9:0] r,
                         input logic [9:0] ext_pat, input int flip_at, input logic flip_pn);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      m[i] = main_out; a[i] = aux_out; r[i] = rx_out;
      ext_in = ext_pat[i];
      if (i == flip_at) pat_n = flip_pn;
    end
  endtask

  task automatic t_reset_start();
    logic [9:0] m, a, r;
    rx_line = 1'b1; par_data = 10'h2B6;
    repeat (3) @(negedge clk);
    chk("R10 outputs in reset", {6'd0, cap_tick, main_out, aux_out, rx_out}, 10'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 capture on first edge", {9'd0, cap_tick}, 10'h1);
    collect(m, a, r, 10'h0, -1, 1'b1);
    chk("R2 first character", m, 10'h2B6);
    chk("R9 rx follows line", r, 10'h3FF);
  endtask

  task automatic t_data();
    logic [9:0] m, a, r;
    logic [9:0] pats [3] = '{10'h2D5, 10'h001, 10'h200};
    rx_line = 1'b1;
    foreach (pats[k]) begin
      launch(pats[k], 1'b1, 1'b1, 1'b0, 1'b0);
      collect(m, a, r, 10'h0, -1, 1'b1);
      chk("R2 data order", m, pats[k]);
      chk("R6 aux idle", a, 10'h0);
    end
    chk("R9 rx follows high line", r, 10'h3FF);
  endtask

  task automatic t_tick();
    logic [9:0] seen;
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        seen[i] = cap_tick;
      end
      chk("R1 tick spacing", seen, 10'h200);
    end
  endtask

  task automatic t_plus();
    logic [9:0] m, a, r;
    launch(10'h155, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      collect(m, a, r, 10'h0, -1, 1'b0);
      chk("R3 positive comma", m, KP);
    end
  endtask

  task automatic t_alt();
    logic [9:0] m, a, r;
    launch(10'h0F0, 1'b1, 1'b1, 1'b0, 1'b0);
    collect(m, a, r, 10'h0, -1, 1'b1);
    launch(10'h0F0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      collect(m, a, r, 10'h0, -1, 1'b0);
      chk("R4 alternating comma", m, (k % 2 == 0) ? KP : KN);
    end
  endtask

  task automatic t_boundary();
    logic [9:0] m, a, r;
    launch(10'h0C3, 1'b1, 1'b1, 1'b0, 1'b0);
    collect(m, a, r, 10'h0, 4, 1'b0);
    chk("R5 data unaffected by late enable", m, 10'h0C3);
    collect(m, a, r, 10'h0, 3, 1'b1);
    chk("R5 comma after boundary", m, KP);
    collect(m, a, r, 10'h0, -1, 1'b1);
    chk("R5 data after disable", m, 10'h0C3);
  endtask

  task automatic t_split();
    logic [9:0] m, a, r;
    logic       prev;
    rx_line = 1'b0;
    launch(10'h2A7, 1'b1, 1'b1, 1'b1, 1'b0);
    prev = ext_in;
    collect(m, a, r, 10'h1B3, -1, 1'b1);
    chk("R7 aux carries data", a, 10'h2A7);
    chk("R7 main repeats ext", m, {10'h1B3 & 10'h1FF} << 1 | {9'd0, prev});
    chk("R9 rx follows low line", r, 10'h0);
  endtask

  task automatic t_loop();
    logic [9:0] m, a, r;
    logic       prev;
    rx_line = 1'b1;
    launch(10'h139, 1'b1, 1'b1, 1'b0, 1'b1);
    collect(m, a, r, 10'h0, -1, 1'b1);
    chk("R8 main quiet", m, 10'h0);
    chk("R8 rx carries data", r, 10'h139);
    chk("R6 aux idle in wrap", a, 10'h0);
    launch(10'h24E, 1'b1, 1'b1, 1'b1, 1'b1);
    prev = ext_in;
    collect(m, a, r, 10'h35A, -1, 1'b1);
    chk("R8 main quiet split", m, 10'h0);
    chk("R8 rx carries ext", r, {10'h35A & 10'h1FF} << 1 | {9'd0, prev});
    chk("R7 aux data in wrap", a, 10'h24E);
    launch(10'h3C1, 1'b1, 1'b1, 1'b0, 1'b0);
    collect(m, a, r, 10'h0, -1, 1'b1);
    chk("R6 main resumes", m, 10'h3C1);
  endtask

  task automatic t_reset_mid();
    logic [9:0] m, a, r;
    rx_line = 1'b1;
    launch(10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 main high mid char", {9'd0, main_out}, 10'h1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 outputs cleared", {6'd0, cap_tick, main_out, aux_out, rx_out}, 10'h0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 restart capture", {9'd0, cap_tick}, 10'h1);
    collect(m, a, r, 10'h0, -1, 1'b1);
    chk("R10 full char after restart", m, 10'h3FF);
  endtask

  initial begin
    fork
      begin
        t_reset_start();
        t_data();
        t_tick();
        t_plus();
        t_alt();
        t_boundary();
        t_split();
        t_loop();
        t_reset_mid();
      end
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule